// File: doc/BRIEF.md
# Interrupt Redirection Controller with Indirect Register Access

This block turns a set of external interrupt pins into interrupt messages for processors. Each pin has one 64-bit redirection entry. The entry sets the vector, delivery mode, destination mode, destination, input polarity, trigger mode and mask for that pin. The block samples the pins and normalises each one by its polarity bit. It detects edge or level events, and it presents one message per event on a valid/ready output. Between an event and its acceptance, the entry shows a delivery-status flag.

Software reaches every internal register through two 32-bit windows. An index register at byte offset 0x00 selects a register, and a data window at byte offset 0x10 reads or writes the selected register. Level-triggered pins use a remote-IRR handshake. Acceptance of a message sets the flag, and a later end-of-interrupt carrying the same vector clears it. A pin that is still active then delivers again. When several pins are waiting, the lowest-numbered pin is served first.

Top module: `irq_router`

## Requirements
- R1: The index register at byte offset 0x00 keeps bits 7:0 of a write and reads back zero-extended. The data window at byte offset 0x10 reads and writes the register that the index selects. Other offsets read zero.
- R2: Index 0x00 holds a read/write ID in bits 27:24. Index 0x02 is read-only and shows that ID in bits 27:24. Index 0x01 is read-only and reads the version 0x20 in bits 7:0 and NPIN-1 in bits 23:16, which is 0x00170020 for 24 pins. Writes to indices 0x01 and 0x02 have no effect.
- R3: Pin n uses index 0x10+2n for the low word and 0x11+2n for the high word.
  - Writable low-word fields: vector in bits 7:0, delivery mode in bits 10:8, logical destination in bit 11, polarity in bit 13, trigger in bit 15 (1 = level) and mask in bit 16.
  - The destination sits in bits 31:24 of the high word.
  - Reserved bits, and indices past the last entry, read zero and ignore writes.
  - After reset, each low word reads 0x00010000 (masked) and each high word reads zero.
- R4: A pin is active when its level XOR polarity is 1. In edge mode, each inactive-to-active transition of an unmasked pin delivers exactly one message, and a pin held active delivers no further message.
- R5: A set mask blocks delivery. An edge that occurs while the pin is masked is dropped, and a later unmask does not deliver it. A level pin that is active while masked delivers once it is unmasked.
- R6: A message carries the entry's vector, mode, logical bit and destination. The message is held stable on the output until ready is seen, and the output is idle in the cycle after acceptance.
- R7: Low-word bit 12 reads 1 from a pin's event until its message is accepted, and reads 0 after acceptance.
- R8: When several pins wait at once, messages leave in ascending pin order, whatever their vectors.
- R9: A level-mode pin delivers when it is active and unmasked and its remote-IRR flag (low-word bit 14) is clear. Acceptance sets bit 14, and no further message follows while bit 14 stays set.
- R10: An end-of-interrupt clears bit 14 on every level entry whose vector matches the end-of-interrupt vector.
  - If the pin is still active, the entry delivers again.
  - An end-of-interrupt with a different vector has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 8 | Byte offset: 0x00 index, 0x10 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed window |
| pins | input | NPIN | Interrupt pins, synchronous to clk |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver takes the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination is logical |
| msg_dest | output | 8 | Destination field |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
The hardest situation to reach is a level-triggered pin that stays active across acceptance and across an end-of-interrupt. Reaching it needs an accepted message, a mismatched end-of-interrupt that must change nothing, and then a matching one that must deliver again. The bench reaches it with a directed sequence that holds the pin high, reads bit 14 back through the data window between the steps, and only then releases the pin. Around that sequence, random entry programming and random single-pin edge deliveries use fixed-seed $urandom values.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_EXTERN = 3'd7
    } dmode_e;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       act_low;
        logic       logical;
        dmode_e     mode;
        logic [7:0] vector;
    } route_cfg_t;

    typedef struct packed {
        logic [7:0] vector;
        dmode_e     mode;
        logic       logical;
        logic [7:0] dest;
    } route_msg_t;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam logic [7:0] OFS_INDEX = 8'h00;
    localparam logic [7:0] OFS_DATA  = 8'h10;

    function automatic logic [31:0] low_word(route_cfg_t c, logic pend, logic rirr);
        return {15'd0, c.mask, c.level, rirr, c.act_low, pend, c.logical, c.mode, c.vector};
    endfunction

    function automatic route_msg_t to_msg(route_cfg_t c);
        route_msg_t m;
        m.vector  = c.vector;
        m.mode    = c.mode;
        m.logical = c.logical;
        m.dest    = c.dest;
        return m;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int         NPIN    = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [7:0]                   bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [NPIN-1:0]              pend,
    input  logic [NPIN-1:0]              rirr,
    output route_cfg_t [NPIN-1:0]        cfg
);
    localparam int          SEL_W    = $clog2(NPIN);
    localparam int unsigned LAST_IDX = 32'(IDX_TBL) + 2 * NPIN - 1;

    logic [7:0]       index_q;
    logic [3:0]       id_q;
    logic             win_idx, win_dat, wr_dat, tbl_hit, hi;
    logic [7:0]       tbl_off;
    logic [SEL_W-1:0] slot;
    logic [31:0]      data_word;
    logic             unused_bits;

    assign win_idx = (bus_addr == OFS_INDEX);
    assign win_dat = (bus_addr == OFS_DATA);
    assign wr_dat  = bus_en && bus_we && win_dat;
    assign tbl_hit = (index_q >= IDX_TBL) && (32'(index_q) <= LAST_IDX);
    assign tbl_off = index_q - IDX_TBL;
    assign slot    = tbl_off[SEL_W:1];
    assign hi      = tbl_off[0];
    assign unused_bits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12], tbl_off};

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            id_q    <= '0;
            for (int i = 0; i < NPIN; i++) begin
                cfg[i]      <= '0;
                cfg[i].mask <= 1'b1;
            end
        end else begin
            if (bus_en && bus_we && win_idx)
                index_q <= bus_wdata[7:0];
            if (wr_dat && index_q == IDX_ID)
                id_q <= bus_wdata[27:24];
            if (wr_dat && tbl_hit) begin
                if (hi) begin
                    cfg[slot].dest <= bus_wdata[31:24];
                end else begin
                    cfg[slot].vector  <= bus_wdata[7:0];
                    cfg[slot].mode    <= dmode_e'(bus_wdata[10:8]);
                    cfg[slot].logical <= bus_wdata[11];
                    cfg[slot].act_low <= bus_wdata[13];
                    cfg[slot].level   <= bus_wdata[15];
                    cfg[slot].mask    <= bus_wdata[16];
                end
            end
        end
    end

    always_comb begin
        data_word = '0;
        case (index_q)
            IDX_ID:  data_word = {4'd0, id_q, 24'd0};
            IDX_VER: data_word = {8'h00, 8'(NPIN - 1), 8'h00, VERSION};
            IDX_ARB: data_word = {4'd0, id_q, 24'd0};
            default: begin
                if (tbl_hit)
                    data_word = hi ? {cfg[slot].dest, 24'd0}
                                   : low_word(cfg[slot], pend[slot], rirr[slot]);
            end
        endcase
    end

    assign bus_rdata = win_idx ? {24'd0, index_q} : (win_dat ? data_word : 32'd0);

    assert_index_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && win_idx) |=> (index_q == $past(index_q)));

endmodule

// File: rtl/irq_pin_track.sv
module irq_pin_track
    import irq_router_pkg::*;
#(
    parameter int NPIN = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       pins,
    input  route_cfg_t [NPIN-1:0] cfg,
    input  logic [NPIN-1:0]       accept,
    input  logic                  eoi_valid,
    input  logic [7:0]            eoi_vector,
    output logic [NPIN-1:0]       pend,
    output logic [NPIN-1:0]       rirr
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic norm, prev_q, fire, eoi_hit, unused_cfg;

        assign norm    = pins[g] ^ cfg[g].act_low;
        assign fire    = !cfg[g].mask &&
                         (cfg[g].level ? (norm && !rirr[g] && !pend[g]) : (norm && !prev_q));
        assign eoi_hit = eoi_valid && cfg[g].level && (cfg[g].vector == eoi_vector);
        assign unused_cfg = ^{cfg[g].dest, cfg[g].mode, cfg[g].logical};

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q  <= 1'b0;
                pend[g] <= 1'b0;
                rirr[g] <= 1'b0;
            end else begin
                prev_q  <= norm;
                pend[g] <= fire || (pend[g] && !accept[g]);
                if (accept[g] && cfg[g].level)
                    rirr[g] <= 1'b1;
                else if (eoi_hit)
                    rirr[g] <= 1'b0;
            end
        end

        assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[g]) |-> $past(!cfg[g].mask));
        assert_rirr_set_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(rirr[g]) |-> $past(accept[g] && cfg[g].level));
        assert_rirr_clear_R10: assert property (@(posedge clk) disable iff (rst)
            (rirr[g] && eoi_hit && !accept[g]) |=> !rirr[g]);
    end

endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_router_pkg::*;
#(
    parameter int NPIN = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPIN-1:0]       pend,
    input  route_cfg_t [NPIN-1:0] cfg,
    input  logic                  msg_ready,
    output logic                  msg_valid,
    output route_msg_t            msg,
    output logic [NPIN-1:0]       accept
);
    localparam int SEL_W = $clog2(NPIN);

    logic [NPIN-1:0]  cand, below_cur;
    logic             found;
    logic [SEL_W-1:0] pick, cur_q;
    logic             unused_cfg;

    always_comb begin
        unused_cfg = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            cand[i]    = pend[i] && !cfg[i].mask;
            unused_cfg = unused_cfg ^ cfg[i].act_low ^ cfg[i].level;
        end
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                pick  = SEL_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            cur_q     <= '0;
            msg       <= '0;
        end else if (msg_valid) begin
            if (msg_ready)
                msg_valid <= 1'b0;
        end else if (found) begin
            msg_valid <= 1'b1;
            cur_q     <= pick;
            msg       <= to_msg(cfg[pick]);
        end
    end

    always_comb begin
        accept = '0;
        if (msg_valid && msg_ready)
            accept[cur_q] = 1'b1;
        below_cur = (NPIN'(1) << cur_q) - NPIN'(1);
    end

    assert_msg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg)));
    assert_one_accept_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(accept));
    assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_valid) |-> (($past(cand) & below_cur) == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NPIN    = 24,
    parameter logic [7:0] VERSION = 8'h20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NPIN-1:0] pins,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [7:0]      msg_vector,
    output logic [2:0]      msg_mode,
    output logic            msg_logical,
    output logic [7:0]      msg_dest,
    input  logic            eoi_valid,
    input  logic [7:0]      eoi_vector
);
    route_cfg_t [NPIN-1:0] cfg;
    logic [NPIN-1:0]       pend, rirr, accept;
    route_msg_t            msg;

    irq_regfile #(.NPIN(NPIN), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .rirr(rirr), .cfg(cfg)
    );

    irq_pin_track #(.NPIN(NPIN)) u_track (
        .clk(clk), .rst(rst), .pins(pins), .cfg(cfg), .accept(accept),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .pend(pend), .rirr(rirr)
    );

    irq_msg_arb #(.NPIN(NPIN)) u_arb (
        .clk(clk), .rst(rst), .pend(pend), .cfg(cfg), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg(msg), .accept(accept)
    );

    assign msg_vector  = msg.vector;
    assign msg_mode    = msg.mode;
    assign msg_logical = msg.logical;
    assign msg_dest    = msg.dest;

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
    localparam int NPIN = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPIN-1:0] pins = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;
    logic        msg_logical;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_router #(.NPIN(NPIN)) i_irq_router (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(pins),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_word(logic [7:0] vec, logic [2:0] mode, logic lg,
                                            logic pol, logic lvl, logic msk);
        return {15'd0, msk, lvl, 1'b0, pol, 1'b0, lg, mode, vec};
    endfunction

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] idx, logic [31:0] d);
        bus_wr(8'h00, {24'd0, idx});
        bus_wr(8'h10, d);
    endtask

    task automatic reg_rd(logic [7:0] idx, output logic [31:0] d);
        bus_wr(8'h00, {24'd0, idx});
        bus_rd(8'h10, d);
    endtask

    task automatic wait_msg(int maxc, output logic got);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (msg_valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic take_msg();
        @(negedge clk); msg_ready = 1'b1;
        @(negedge clk); msg_ready = 1'b0;
    endtask

    task automatic quiet(string req, int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic send_eoi(logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic edge_case(int p, logic [7:0] vec, logic [2:0] mode, logic lg,
                             logic pol, logic [7:0] dest);
        logic        got;
        logic [31:0] d;
        logic [7:0]  lo_idx = 8'(8'h10 + 2 * p);
        reg_wr(lo_idx + 8'd1, {dest, 24'd0});
        reg_wr(lo_idx, lo_word(vec, mode, lg, pol, 1'b0, 1'b1));
        pins[p] = pol;
        repeat (3) @(negedge clk);
        reg_wr(lo_idx, lo_word(vec, mode, lg, pol, 1'b0, 1'b0));
        pins[p] = ~pol;
        wait_msg(10, got);
        check("R4 edge delivers", {31'd0, got}, 32'd1);
        check("R6 vector", {24'd0, msg_vector}, {24'd0, vec});
        check("R6 mode/logical/dest", {20'd0, msg_mode, msg_logical, msg_dest},
              {20'd0, mode, lg, dest});
        reg_rd(lo_idx, d);
        check("R7 status set while held", {31'd0, d[12]}, 32'd1);
        check("R6 held until ready", {msg_valid, 23'd0, msg_vector}, {1'b1, 23'd0, vec});
        take_msg();
        check("R6 idle after accept", {31'd0, msg_valid}, 32'd0);
        reg_rd(lo_idx, d);
        check("R7 status clear after accept", {31'd0, d[12]}, 32'd0);
        quiet("R4 single message per edge", 6);
        reg_wr(lo_idx, 32'h0001_0000);
        pins[p] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d, w;
        logic        got;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R6 reset idle", {31'd0, msg_valid}, 32'd0);
        reg_rd(8'h10, d); check("R3 reset low word", d, 32'h0001_0000);
        reg_rd(8'h3F, d); check("R3 reset high word", d, 32'h0);

        // Index window and identity registers
        reg_rd(8'h01, d); check("R2 version", d, 32'h0017_0020);
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, d); check("R2 id readback", d, 32'h0F00_0000);
        reg_rd(8'h02, d); check("R2 arbitration mirrors id", d, 32'h0F00_0000);
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd(8'h01, d); check("R2 version write ignored", d, 32'h0017_0020);
        bus_wr(8'h00, 32'h1234_5601);
        bus_rd(8'h00, d); check("R1 index keeps low byte", d, 32'h0000_0001);
        bus_rd(8'h10, d); check("R1 data window follows index", d, 32'h0017_0020);
        bus_rd(8'h08, d); check("R1 other offset reads zero", d, 32'h0);
        reg_wr(8'h40, 32'hFFFF_FFFF);
        reg_rd(8'h40, d); check("R3 out of range index", d, 32'h0);
        reg_rd(8'h3F, d); check("R3 last entry untouched", d, 32'h0);

        // Random entry programming with the mask kept set
        for (int i = 0; i < 20; i++) begin
            int p = $urandom_range(0, NPIN - 1);
            w = $urandom | 32'h0001_0000;
            reg_wr(8'(8'h10 + 2 * p), w);
            reg_rd(8'(8'h10 + 2 * p), d);
            check("R3 low word fields", d, w & 32'h0001_AFFF);
            w = $urandom;
            reg_wr(8'(8'h11 + 2 * p), w);
            reg_rd(8'(8'h11 + 2 * p), d);
            check("R3 high word fields", d, w & 32'hFF00_0000);
        end
        for (int p = 0; p < NPIN; p++) reg_wr(8'(8'h10 + 2 * p), 32'h0001_0000);

        // Random edge deliveries
        for (int i = 0; i < 8; i++) begin
            edge_case($urandom_range(0, NPIN - 1), 8'($urandom_range(16, 254)),
                      3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
        end
        edge_case(NPIN - 1, 8'hFE, 3'd7, 1'b1, 1'b1, 8'hA5);

        // Masked edge is dropped
        reg_wr(8'h10 + 8'd8, lo_word(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        pins[4] = 1'b1;
        quiet("R5 masked edge silent", 6);
        reg_wr(8'h10 + 8'd8, lo_word(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        quiet("R5 dropped edge not delivered on unmask", 8);
        reg_wr(8'h10 + 8'd8, 32'h0001_0000);
        pins[4] = 1'b0;

        // Lowest pin first, regardless of vector
        reg_wr(8'h10 + 8'd6,  lo_word(8'h91, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        reg_wr(8'h10 + 8'd14, lo_word(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        repeat (2) @(negedge clk);
        pins[3] = 1'b1; pins[7] = 1'b1;
        wait_msg(10, got);
        check("R8 first message from pin 3", {23'd0, got, msg_vector}, {23'd0, 1'b1, 8'h91});
        take_msg();
        wait_msg(10, got);
        check("R8 second message from pin 7", {23'd0, got, msg_vector}, {23'd0, 1'b1, 8'h22});
        take_msg();
        reg_wr(8'h10 + 8'd6,  32'h0001_0000);
        reg_wr(8'h10 + 8'd14, 32'h0001_0000);
        pins[3] = 1'b0; pins[7] = 1'b0;

        // Level pin with remote-IRR handshake
        reg_wr(8'h10 + 8'd10, lo_word(8'h55, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        pins[5] = 1'b1;
        wait_msg(10, got);
        check("R9 level delivers", {23'd0, got, msg_vector}, {23'd0, 1'b1, 8'h55});
        take_msg();
        reg_rd(8'h10 + 8'd10, d);
        check("R9 remote-IRR set on accept", {31'd0, d[14]}, 32'd1);
        quiet("R9 no redelivery while remote-IRR set", 8);
        send_eoi(8'h56);
        quiet("R10 mismatched EOI no effect", 6);
        reg_rd(8'h10 + 8'd10, d);
        check("R10 mismatched EOI keeps flag", {31'd0, d[14]}, 32'd1);
        send_eoi(8'h55);
        wait_msg(10, got);
        check("R10 EOI with active pin redelivers", {23'd0, got, msg_vector}, {23'd0, 1'b1, 8'h55});
        take_msg();
        pins[5] = 1'b0;
        send_eoi(8'h55);
        quiet("R10 EOI with idle pin silent", 6);
        reg_rd(8'h10 + 8'd10, d);
        check("R10 remote-IRR cleared", {31'd0, d[14]}, 32'd0);
        reg_wr(8'h10 + 8'd10, 32'h0001_0000);

        // Active-low level pin held while masked
        reg_wr(8'h10 + 8'd12, lo_word(8'h66, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1));
        quiet("R5 masked level silent", 6);
        reg_wr(8'h10 + 8'd12, lo_word(8'h66, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0));
        wait_msg(10, got);
        check("R5 level delivers after unmask", {20'd0, got, msg_mode, msg_vector},
              {20'd0, 1'b1, 3'd4, 8'h66});
        take_msg();
        reg_wr(8'h10 + 8'd12, 32'h0001_0000);
        send_eoi(8'h66);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule